// File: doc/BRIEF.md
# Serial Port Byte-Paced DMA Channel

This block is a single DMA channel dedicated to one serial port. It moves bytes between a byte-wide memory port and the port's data register. The port's flags pace each transfer: in transmit direction, a set transmit-empty flag asks for the next byte, and in receive direction, a set receive-full flag asks for the received byte to be stored. Each access the channel makes to the data register is what clears the flag in the port.

Software writes the start address, the byte count and a control word holding direction, activate bit, interrupt enables and a priority value. It then sets the activate bit. The channel walks memory upward one byte per transfer. It raises a half-way flag and a done flag, which stay set until software clears them, and it drives an interrupt from them. Once the count is used up, further flags from the port are left unanswered. Software then waits on the port's own transmission-complete indication before it shuts the port down.

Configuration offsets: 0 = control (bit0 activate, bit1 direction with 1 = transmit, bit2 half-way interrupt enable, bit3 done interrupt enable, bits5:4 priority), 1 = memory start address, 2 = byte count, 3 = flag clear (bit0 clears done, bit1 clears half-way, write one to clear).

Top module: `serdma_channel`

## Requirements
- R1: In transmit direction (control bit1 = 1), each accepted request reads one memory byte and presents it on `dr_wdata` during a single-cycle `dr_wr` pulse. Bytes come from the start address upward, one address per transfer.
- R2: In receive direction (control bit1 = 0), each accepted request produces a single-cycle `dr_rd` pulse. The byte on `dr_rdata` in that cycle is written to memory at the next address.
- R3: A request is accepted only while control bit0 (activate) is 1, the remaining count is nonzero, and the port's DMA enable input for the selected direction is high. Otherwise the flag is left pending and no data-register strobe occurs.
- R4: A channel programmed with count N performs exactly N transfers. After the last one, further flags from the port cause no strobe.
- R5: After a transfer, the channel accepts no new request until it has seen the selected flag low, so a flag held high yields only one transfer.
- R6: `ht_flag` sets when the remaining count, after a transfer, equals floor(N/2).
- R7: `tc_flag` sets when the remaining count reaches zero.
- R8: `irq` is high exactly when (`tc_flag` and control bit3) or (`ht_flag` and control bit2).
- R9: Writing offset 3 with bit0 = 1 clears `tc_flag`, and with bit1 = 1 clears `ht_flag`. Flags set again by a transfer in the same cycle stay set.
- R10: Clearing the activate bit stops new transfers and keeps the current address and count, and setting it again resumes from them. Writes to offsets 1 and 2 are ignored while the activate bit is 1.
- R11: Once `mem_req` is raised, it stays high with a stable address, direction and write data until `mem_ack` is seen.
- R12: After reset, `mem_req`, `dr_wr`, `dr_rd`, `tc_flag`, `ht_flag` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register offset |
| cfg_wdata | input | CFG_W | Configuration write data |
| chan_prio | output | 2 | Stored priority value for an external arbiter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access completes |
| ser_tx_empty | input | 1 | Port transmit data register empty |
| ser_rx_full | input | 1 | Port receive data register full |
| ser_tx_dma_en | input | 1 | Port allows DMA in transmit direction |
| ser_rx_dma_en | input | 1 | Port allows DMA in receive direction |
| dr_wr | output | 1 | Data register write pulse |
| dr_wdata | output | 8 | Data register write byte |
| dr_rd | output | 1 | Data register read pulse |
| dr_rdata | input | 8 | Data register read byte |
| tc_flag | output | 1 | Transfer-complete flag |
| ht_flag | output | 1 | Half-way flag |
| irq | output | 1 | Channel interrupt |

## Verification
On every cycle, the assertions check the step of address and count per completed transfer, the holding of a memory request until it is acknowledged, the ban on a new acceptance in the cycle after a transfer, the idle state while deactivated, and that the flags set on their events and clear on a write-one-to-clear. Only the bench's scenarios can show byte order and content in both directions, the exact number of transfers against a flag that stays high after the count runs out, and the half-way threshold for every count from 1 to 5. They also cover gating by the port's enable and by a zero count, and resumption at the held address after deactivation.

// File: rtl/serdma_pkg.sv
package serdma_pkg;

  // configuration offsets
  localparam logic [1:0] OFS_CTRL  = 2'd0;
  localparam logic [1:0] OFS_MADDR = 2'd1;
  localparam logic [1:0] OFS_COUNT = 2'd2;
  localparam logic [1:0] OFS_FCLR  = 2'd3;

  // control word, bit0 = activate
  typedef struct packed {
    logic [1:0] prio;
    logic       tc_ie;
    logic       ht_ie;
    logic       dir_tx;
    logic       act;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRD,   // transmit: fetch byte from memory
    ST_DRW,   // transmit: write data register
    ST_DRR,   // receive: read data register
    ST_MWR    // receive: store byte to memory
  } xfer_state_e;

  // remaining count at which the half-way flag sets
  function automatic int unsigned half_point(input int unsigned total);
    return total / 2;
  endfunction

  function automatic logic irq_of(input ctrl_t c, input logic tcf, input logic htf);
    return (tcf & c.tc_ie) | (htf & c.ht_ie);
  endfunction

endpackage

// File: rtl/serdma_cfg.sv
module serdma_cfg
  import serdma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ev_half,
  input  logic          ev_last,
  output ctrl_t         ctrl,
  output logic          ld_addr,
  output logic [AW-1:0] ld_addr_val,
  output logic          ld_cnt,
  output logic [CW-1:0] ld_cnt_val,
  output logic          tc_flag,
  output logic          ht_flag,
  output logic          irq
);

  ctrl_t ctrl_q;
  logic  tc_q, ht_q;
  logic  wr_ctrl, wr_fclr, clr_tc, clr_ht;

  assign wr_ctrl     = wr_en && (wr_addr == OFS_CTRL);
  assign wr_fclr     = wr_en && (wr_addr == OFS_FCLR);
  assign clr_tc      = wr_fclr && wr_data[0];
  assign clr_ht      = wr_fclr && wr_data[1];
  assign ld_addr     = wr_en && (wr_addr == OFS_MADDR) && !ctrl_q.act;
  assign ld_cnt      = wr_en && (wr_addr == OFS_COUNT) && !ctrl_q.act;
  assign ld_addr_val = wr_data[AW-1:0];
  assign ld_cnt_val  = wr_data[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tc_q   <= 1'b0;
      ht_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      tc_q <= ev_last | (tc_q & ~clr_tc);
      ht_q <= ev_half | (ht_q & ~clr_ht);
    end
  end

  assign ctrl    = ctrl_q;
  assign tc_flag = tc_q;
  assign ht_flag = ht_q;
  assign irq     = irq_of(ctrl_q, tc_q, ht_q);

  assert_tc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> tc_flag);
  assert_tc_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(ev_last));
  assert_ht_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_half |=> ht_flag);
  assert_tc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tc && !ev_last) |=> !tc_flag);
  assert_ht_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ht && !ev_half) |=> !ht_flag);

endmodule

// File: rtl/serdma_xfer.sv
module serdma_xfer
  import serdma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          dir_tx,
  input  logic          ld_addr,
  input  logic [AW-1:0] ld_addr_val,
  input  logic          ld_cnt,
  input  logic [CW-1:0] ld_cnt_val,
  input  logic          tx_empty,
  input  logic          rx_full,
  input  logic          tx_dma_en,
  input  logic          rx_dma_en,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack,
  output logic          dr_wr,
  output logic [7:0]    dr_wdata,
  output logic          dr_rd,
  input  logic [7:0]    dr_rdata,
  output logic          ev_half,
  output logic          ev_last
);

  xfer_state_e   st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q, total_q, cnt_next, half_cnt;
  logic [7:0]    byte_q;
  logic          armed_q;

  // named internal events
  logic flag_raw, flag_req, start, ev_done;

  assign flag_raw = dir_tx ? tx_empty : rx_full;
  assign flag_req = flag_raw & (dir_tx ? tx_dma_en : rx_dma_en);
  assign start    = (st_q == ST_IDLE) && act && armed_q && (cnt_q != '0) && flag_req;
  assign cnt_next = cnt_q - CW'(1);
  assign half_cnt = CW'(half_point(32'(total_q)));

  always_comb begin
    st_d    = st_q;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    dr_wr   = 1'b0;
    dr_rd   = 1'b0;
    ev_done = 1'b0;
    case (st_q)
      ST_IDLE: if (start) st_d = dir_tx ? ST_MRD : ST_DRR;
      ST_MRD: begin
        mem_req = 1'b1;
        if (mem_ack) st_d = ST_DRW;
      end
      ST_DRW: begin
        dr_wr   = 1'b1;
        ev_done = 1'b1;
        st_d    = ST_IDLE;
      end
      ST_DRR: begin
        dr_rd = 1'b1;
        st_d  = ST_MWR;
      end
      ST_MWR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          ev_done = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign ev_last   = ev_done && (cnt_next == '0);
  assign ev_half   = ev_done && (cnt_next == half_cnt);
  assign mem_addr  = addr_q;
  assign mem_wdata = byte_q;
  assign dr_wdata  = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      total_q <= '0;
      byte_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_q == ST_MRD && mem_ack) byte_q <= mem_rdata;
      if (st_q == ST_DRR)            byte_q <= dr_rdata;
      if (ev_done) begin
        addr_q  <= addr_q + AW'(1);
        cnt_q   <= cnt_next;
        armed_q <= 1'b0;
      end else begin
        if (ld_addr) addr_q <= ld_addr_val;
        if (ld_cnt) begin
          cnt_q   <= ld_cnt_val;
          total_q <= ld_cnt_val;
        end
        if (st_q == ST_IDLE && !flag_raw) armed_q <= 1'b1;
      end
    end
  end

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !ld_addr) |=> (mem_addr == $past(mem_addr) + AW'(1)));
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (cnt_q == $past(cnt_q) - CW'(1)));
  assert_no_strobe_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_wr || dr_rd) |-> (cnt_q != '0));
  assert_one_per_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !start);
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !act) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/serdma_channel.sv
module serdma_channel
  import serdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CFG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [1:0]        chan_prio,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  input  logic              ser_tx_empty,
  input  logic              ser_rx_full,
  input  logic              ser_tx_dma_en,
  input  logic              ser_rx_dma_en,
  output logic              dr_wr,
  output logic [7:0]        dr_wdata,
  output logic              dr_rd,
  input  logic [7:0]        dr_rdata,
  output logic              tc_flag,
  output logic              ht_flag,
  output logic              irq
);

  ctrl_t             ctrl;
  logic              ld_addr, ld_cnt, ev_half, ev_last;
  logic [ADDR_W-1:0] ld_addr_val;
  logic [CNT_W-1:0]  ld_cnt_val;

  serdma_cfg #(.AW(ADDR_W), .CW(CNT_W), .DW(CFG_W)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .ev_half(ev_half), .ev_last(ev_last),
    .ctrl(ctrl),
    .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
    .ld_cnt(ld_cnt), .ld_cnt_val(ld_cnt_val),
    .tc_flag(tc_flag), .ht_flag(ht_flag), .irq(irq)
  );

  serdma_xfer #(.AW(ADDR_W), .CW(CNT_W)) xfer_i (
    .clk(clk), .rst_n(rst_n),
    .act(ctrl.act), .dir_tx(ctrl.dir_tx),
    .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
    .ld_cnt(ld_cnt), .ld_cnt_val(ld_cnt_val),
    .tx_empty(ser_tx_empty), .rx_full(ser_rx_full),
    .tx_dma_en(ser_tx_dma_en), .rx_dma_en(ser_rx_dma_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_rd(dr_rd), .dr_rdata(dr_rdata),
    .ev_half(ev_half), .ev_last(ev_last)
  );

  assign chan_prio = ctrl.prio;

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(dr_wr && dr_rd));
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tc_flag || ht_flag));

endmodule

// File: tb/serdma_channel_tb_top.sv
`timescale 1ns/1ps
module serdma_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  chan_prio;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack;
  logic        tx_empty, rx_full;
  logic        tx_en = 1'b1, rx_en = 1'b1;
  logic        dr_wr, dr_rd;
  logic [7:0]  dr_wdata;
  logic [7:0]  rx_data = '0;
  logic        tc_flag, ht_flag, irq;

  always #5 clk = ~clk;

  serdma_channel dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .chan_prio(chan_prio),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ser_tx_empty(tx_empty), .ser_rx_full(rx_full),
    .ser_tx_dma_en(tx_en), .ser_rx_dma_en(rx_en),
    .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_rd(dr_rd), .dr_rdata(rx_data),
    .tc_flag(tc_flag), .ht_flag(ht_flag), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model with programmable latency
  logic [7:0] mem [0:255];
  int lat = 0;
  int lat_cnt = 0;
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat_cnt >= lat) begin
        mem_ack <= 1'b1;
        lat_cnt <= 0;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      end else lat_cnt <= lat_cnt + 1;
    end else mem_ack <= 1'b0;
  end

  // request-hold monitor (R11)
  logic prev_req, prev_ack;
  int   hold_viol = 0;
  always @(posedge clk) begin
    if (rst_n && prev_req && !prev_ack && !mem_req) hold_viol++;
    prev_req <= mem_req;
    prev_ack <= mem_ack;
  end

  // serial transmit side: flag clears on write, sets 4 cycles later
  logic [7:0] txlog [0:63];
  int txn = 0;
  int shcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      shcnt    <= 0;
    end else if (dr_wr) begin
      tx_empty <= 1'b0;
      txlog[txn[5:0]] <= dr_wdata;
      txn   <= txn + 1;
      shcnt <= 4;
    end else if (shcnt != 0) begin
      shcnt <= shcnt - 1;
      if (shcnt == 1) tx_empty <= 1'b1;
    end
  end

  // serial receive side
  logic rx_push = 1'b0, rx_stick = 1'b0, rx_drop = 1'b0;
  int   rdcount = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_full <= 1'b0;
    else if (rx_push) rx_full <= 1'b1;
    else if ((dr_rd && !rx_stick) || rx_drop) rx_full <= 1'b0;
    if (rst_n && dr_rd) rdcount <= rdcount + 1;
  end

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk);
    rx_data = v; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic drop();
    @(negedge clk); rx_drop = 1'b1;
    @(negedge clk); rx_drop = 1'b0;
  endtask

  task automatic setup(input int base, input int n, input logic [15:0] ctrl);
    cfg_write(2'd0, 16'h0000);
    cfg_write(2'd3, 16'h0003);
    cfg_write(2'd1, 16'(base));
    cfg_write(2'd2, 16'(n));
    cfg_write(2'd0, ctrl);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!mem_req && !dr_wr && !dr_rd, "R12 strobes low in reset", int'(mem_req), 0);
    chk(!tc_flag && !ht_flag && !irq, "R12 flags low in reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tc_flag && !ht_flag && !irq && !mem_req, "R12 idle after reset", int'(tc_flag), 0);
    chk(txn == 0 && rdcount == 0, "R3 no transfer while inactive", txn, 0);

    // transmit sweep: N = 1..5, interrupt enables vary with N
    for (int n = 1; n <= 5; n++) begin
      int base, t0, g;
      logic [1:0] ie;
      base = n * 16;
      ie   = 2'(n);
      lat  = n % 3;
      t0   = txn;
      setup(base, n, {12'd0, ie[1], ie[0], 2'b11});
      g = 0;
      while (!tc_flag && g < 400) begin @(negedge clk); g++; end
      repeat (30) @(negedge clk);
      chk(txn - t0 == n, "R4 transmit count exact with flag held high", txn - t0, n);
      for (int i = 0; i < n; i++)
        chk(txlog[(t0 + i) % 64] == mem[base + i], "R1 transmit byte order",
            int'(txlog[(t0 + i) % 64]), int'(mem[base + i]));
      chk(tc_flag, "R7 transmit done flag", int'(tc_flag), 1);
      chk(ht_flag, "R6 transmit half-way flag", int'(ht_flag), 1);
      chk(irq == (ie != 2'b00), "R8 irq against enables", int'(irq), int'(ie != 2'b00));
    end
    chk(chan_prio == 2'b00, "R10 priority stored", int'(chan_prio), 0);

    // receive sweep: N = 1..5, half-way interrupt only
    tx_en = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      int base, r0, half;
      logic [7:0] v;
      bit ht_exp;
      base = 128 + n * 8;
      lat  = n % 3;
      half = n / 2;
      setup(base, n, 16'h0015);
      chk(chan_prio == 2'b01, "R10 priority field write", int'(chan_prio), 1);
      for (int k = 1; k <= n; k++) begin
        v = 8'((k * 13 + n * 29) & 255);
        push(v);
        repeat (14) @(negedge clk);
        ht_exp = ((n - k) <= half);
        chk(mem[base + k - 1] == v, "R2 receive byte stored", int'(mem[base + k - 1]), int'(v));
        chk(ht_flag == ht_exp, "R6 half-way threshold", int'(ht_flag), int'(ht_exp));
        chk(tc_flag == (k == n), "R7 done at last byte", int'(tc_flag), int'(k == n));
        chk(irq == ht_exp, "R8 irq follows half-way enable", int'(irq), int'(ht_exp));
      end
      r0 = rdcount;
      push(8'hEE);
      repeat (20) @(negedge clk);
      chk(rdcount == r0 && rx_full, "R4 request ignored after count used", rdcount - r0, 0);
      chk(mem[base + n] == 8'((base + n) * 7 + 3), "R4 memory untouched after count", int'(mem[base + n]), (base + n) * 7 + 3);
      drop();
      if (n == 5) begin
        cfg_write(2'd3, 16'h0001);
        @(negedge clk);
        chk(!tc_flag && ht_flag, "R9 clear done only", int'(tc_flag), 0);
        cfg_write(2'd3, 16'h0002);
        @(negedge clk);
        chk(!ht_flag && !irq, "R9 clear half-way", int'(ht_flag), 0);
      end
    end

    // gating, one-per-request, deactivate and resume
    begin
      int r0;
      lat = 1;
      rx_en = 1'b0;
      setup(192, 8, 16'h0001);
      r0 = rdcount;
      push(8'h5A);
      repeat (20) @(negedge clk);
      chk(rdcount == r0 && rx_full, "R3 port enable low blocks request", rdcount - r0, 0);
      rx_en = 1'b1;
      repeat (14) @(negedge clk);
      chk(rdcount == r0 + 1 && mem[192] == 8'h5A, "R3 request served once enabled", int'(mem[192]), 'h5A);
      rx_stick = 1'b1;
      push(8'h66);
      repeat (30) @(negedge clk);
      chk(rdcount == r0 + 2, "R5 single transfer for held flag", rdcount - r0, 2);
      chk(mem[194] == 8'((194 * 7 + 3) & 255), "R5 no duplicate store", int'(mem[194]), (194 * 7 + 3) & 255);
      drop();
      rx_stick = 1'b0;
      repeat (3) @(negedge clk);
      cfg_write(2'd0, 16'h0000);
      push(8'h77);
      repeat (20) @(negedge clk);
      chk(rdcount == r0 + 2 && rx_full, "R10 no transfer while deactivated", rdcount - r0, 2);
      cfg_write(2'd0, 16'h0001);
      repeat (14) @(negedge clk);
      chk(mem[194] == 8'h77, "R10 resume at held address", int'(mem[194]), 'h77);
      cfg_write(2'd1, 16'h0040);
      push(8'h88);
      repeat (14) @(negedge clk);
      chk(mem[195] == 8'h88, "R10 address write ignored while active", int'(mem[195]), 'h88);
      chk(mem[64] == 8'((64 * 7 + 3) & 255), "R10 ignored address not used", int'(mem[64]), (64 * 7 + 3) & 255);
      // zero count
      setup(200, 0, 16'h0001);
      r0 = rdcount;
      push(8'h99);
      repeat (20) @(negedge clk);
      chk(rdcount == r0 && !tc_flag, "R3 zero count never transfers", rdcount - r0, 0);
      drop();
    end

    chk(hold_viol == 0, "R11 memory request held until ack", hold_viol, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule